// File: doc/BRIEF.md
# Set-only strobed parallel register

This block holds a word of parameterised width in a row of storage bits that can only be set by a load and only cleared by a separate clear strobe. A load strobe ORs the data word into the stored word, so every bit whose data input is high becomes 1. Bits that are already 1 stay at 1, and bits whose data is low keep their value. To store a fresh word, the user first pulses clear and then pulses load. Skipping the clear merges stale ones with the new word.

The stored word reaches the output only while the read strobe is high. At all other times every output bit is held low. The strobes are sampled on the rising clock edge. The output gating is combinational, so a read presents the word in the same cycle as its strobe. All bits load together on one load pulse and are presented together on one read pulse. The interface carries no flow control: the three strobes and the data word are plain control and data pins. No valid/ready handshake and no back-pressure exist, because a load always completes in one cycle and a read is a pure gate.

Top module: `strobed_set_register`

## Requirements
- R1: After the active-low system reset `rst_n`, every stored bit is 0 and `word_out` is all zeros.
- R2: A cycle with `clear_stb` high leaves every stored bit at 0 after the next rising edge, whatever the earlier contents were.
- R3: A cycle with `load_stb` high and `clear_stb` low sets, at the next rising edge, every stored bit i whose `word_in[i]` is 1. All bits are taken on that single edge.
- R4: A load never clears a bit. A bit whose `word_in[i]` is 0 keeps its value, so a load without a prior clear stores the bitwise OR of the old word and the new word.
- R5: `word_out[i]` equals stored bit i while `read_stb` is high, in the same cycle and without a clock edge. While `read_stb` is low, `word_out` is all zeros.
- R6: When `clear_stb` and `load_stb` are both high in the same cycle, the clear wins and the register ends that cycle at all zeros.
- R7: With neither `clear_stb` nor `load_stb` high, the stored word is unchanged across the edge, including across read cycles.
- R8: Bit positions are preserved: `word_in[i]` is stored in bit i and appears on `word_out[i]`. For example, with WIDTH 4, loading 4'b1101 after a clear reads back as 4'b1101, and bit 1 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low system reset that clears the stored word |
| clear_stb | input | 1 | Clear strobe; zeros all bits at the next edge |
| load_stb | input | 1 | Load strobe; sets the bits selected by word_in |
| word_in | input | WIDTH | Parallel data word to merge into storage |
| read_stb | input | 1 | Read strobe; gates the stored word onto word_out |
| word_out | output | WIDTH | Stored word ANDed with read_stb |

## Verification
Clear and load are the two functions that can fall in the same cycle. The bench first fills the register with a nonzero word. It then drives clear_stb and load_stb high together with a nonzero word_in. In the next cycle it reads the register and expects all zeros, because the clear has priority. Reads are also taken in the same cycle as other strobes, to confirm that the combinational gate shows the word held before the edge.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    CELL_HOLD  = 2'd0,
    CELL_SET   = 2'd1,
    CELL_CLEAR = 2'd2
  } cell_op_e;
endpackage

// File: rtl/ssr_cell.sv
module ssr_cell
  import ssr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_stb,
  input  logic load_stb,
  input  logic data_bit,
  output logic held
);
  cell_op_e op;

  always_comb begin
    if (clear_stb)                 op = CELL_CLEAR;
    else if (load_stb && data_bit) op = CELL_SET;
    else                           op = CELL_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else begin
      case (op)
        CELL_CLEAR: held <= 1'b0;
        CELL_SET:   held <= 1'b1;
        default:    held <= held;
      endcase
    end
  end

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_stb |=> !held);
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_stb && !load_stb) |=> !held);
  assert_load_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && data_bit && !clear_stb) |=> held);
  assert_never_cleared_by_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !clear_stb) |=> held);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_stb && !load_stb) |=> $stable(held));
endmodule

// File: rtl/ssr_out_gate.sv
module ssr_out_gate #(
  parameter int WIDTH = 4
) (
  input  logic             read_stb,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] gated
);
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    assign gated[i] = stored[i] & read_stb;
  end

  always_comb begin
    if (!read_stb) assert_quiet_R5: assert (gated == ALL_ZERO);
    else           assert_pass_R8:  assert (gated == stored);
  end
endmodule

// File: rtl/strobed_set_register.sv
module strobed_set_register #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_stb,
  input  logic             load_stb,
  input  logic [WIDTH-1:0] word_in,
  input  logic             read_stb,
  output logic [WIDTH-1:0] word_out
);
  logic [WIDTH-1:0] stored;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    ssr_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_stb (clear_stb),
      .load_stb  (load_stb),
      .data_bit  (word_in[i]),
      .held      (stored[i])
    );
  end

  ssr_out_gate #(.WIDTH(WIDTH)) u_gate (
    .read_stb (read_stb),
    .stored   (stored),
    .gated    (word_out)
  );

  assert_or_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !clear_stb) |=> (stored == ($past(stored) | $past(word_in))));
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (stored == '0) || !rst_n);
endmodule

// File: tb/tb_strobed_set_register.sv
module tb_strobed_set_register;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] exp;
    string        req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear_stb = 1'b0;
  logic         load_stb = 1'b0;
  logic [W-1:0] word_in = '0;
  logic         read_stb = 1'b0;
  logic [W-1:0] word_out;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;
  item_t sb[$];
  bit done = 1'b0;

  strobed_set_register #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .clear_stb(clear_stb), .load_stb(load_stb),
    .word_in(word_in), .read_stb(read_stb), .word_out(word_out)
  );

  always #5 clk = ~clk;

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Monitor: while a read strobe is up, pop the scoreboard and compare.
  always @(negedge clk) begin
    if (read_stb && rst_n) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %b expected none", word_out);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(word_out, it.exp, it.req);
      end
    end
  end

  // Drive one cycle of strobes; read may accompany them (sees pre-edge word).
  task automatic drive(input logic c, input logic l, input logic [W-1:0] d,
                       input logic r, input string req);
    @(posedge clk); #1;
    clear_stb = c; load_stb = l; word_in = d; read_stb = r;
    if (r) sb.push_back('{model, req});
    if (c)      model = '0;
    else if (l) model = model | d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, '0, 1'b0, "");
  endtask

  task automatic read(input string req);
    drive(1'b0, 1'b0, '0, 1'b1, req);
  endtask

  task automatic check_quiet(input string req);
    @(negedge clk);
    check(word_out, '0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    read("R1 reset state");
    idle();
    check_quiet("R1 output low after reset");

    // Preload stale ones, then clear, then load 1101
    drive(1'b0, 1'b1, 4'b0010, 1'b0, "");
    read("R4 preload");
    drive(1'b1, 1'b0, '0, 1'b0, "");
    read("R2 clear");
    drive(1'b0, 1'b1, 4'b1101, 1'b0, "");
    read("R8 word 1101");
    read("R3 parallel load");
    idle();
    check_quiet("R5 read low gives zero");

    // Load without clear merges
    drive(1'b0, 1'b1, 4'b0010, 1'b0, "");
    read("R4 OR merge 1111");
    // Load with zeros keeps bits
    drive(1'b0, 1'b1, 4'b0000, 1'b1, "R4 pre-edge read");
    read("R4 zero data keeps bits");

    // Clear and load together
    drive(1'b1, 1'b1, 4'b1011, 1'b0, "");
    read("R6 clear beats load");

    // Hold across idle and reads
    drive(1'b0, 1'b1, 4'b1010, 1'b0, "");
    idle(); idle();
    read("R7 hold");
    read("R7 hold across read");
    drive(1'b0, 1'b1, 4'b0101, 1'b0, "");
    read("R4 merge to 1111 again");
    drive(1'b1, 1'b0, '0, 1'b1, "R2 read in clear cycle");
    read("R2 clear from 1111");
    idle();
    check_quiet("R5 idle low");
    idle();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule